// File: doc/BRIEF.md
# Dual interval timer

Two independent 32-bit interval timers sit behind a small register port. Each timer holds a count, a limit and a two-bit control field. The count steps up by one per counting cycle. When an increment is due while the count equals the limit, the count returns to 0 instead, so the timer repeats with a period of limit + 1 counting cycles. That wrap can latch a level interrupt, which stays high until software writes the timer's control register with any value.

Software arms a timer in three writes: the limit, then a starting count (normally 0), then the control field. One control bit lets the timer count every clock. The other lets it count only while the processor's halted input is low. With the limit at all ones, the count runs through the full 32-bit range and serves as a free-running time base.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, every count, limit and control field reads 0 and both interrupt outputs are low.
- R2: Timer 0 decodes count at address 0x021, control at 0x022 and limit at 0x023. Timer 1 decodes count at 0x100, control at 0x101 and limit at 0x102. Reads are combinational. Control reads back in bits [1:0] with zeros above. Other addresses read 0, and writes to them change nothing.
- R3: A count write loads the written value at the next clock edge. It takes precedence over that cycle's increment and over any wrap in that cycle.
- R4: With control bit 1 set, the count advances only on clock edges where cpu_halted is low.
- R5: With control bit 1 clear, the count advances on every clock edge, whatever cpu_halted is.
- R6: When an increment is due and the count equals the limit, the count becomes 0 at that edge.
- R7: If control bit 0 (interrupt enable) is set when a wrap occurs, that timer's irq bit goes high at the wrap edge. With bit 0 clear, a wrap leaves irq low.
- R8: A raised irq bit stays high until a write to that timer's control register. Any such write clears it, and a control write at the same edge as a wrap leaves it low.
- R9: The timers are independent: registers, counting and interrupt of one are unaffected by accesses to the other.
- R10: With the limit at 0xFFFFFFFF, the count passes 0xFFFFFFFE, 0xFFFFFFFF and then 0 on successive counting edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_halted | input | 1 | High while the processor is halted |
| reg_addr | input | 12 | Register address |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| irq | output | 2 | Sticky interrupt level, one bit per timer |

## Verification
A corrupted count shows on the very next read of that count, and it skews the wrap edge, so irq rises early or late by the same number of cycles. A lost or stray pending flag is visible on irq in the cycle after the faulty edge. An enable or halt-gating bit that is held wrong shows up within one counting window, either as a count that should have moved or frozen or as a missing irq. The bench freezes counting with the halt input, so every read has one exact expected value.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

    localparam int unsigned CTRL_W     = 2;
    localparam int unsigned IE_BIT     = 0;
    localparam int unsigned NH_BIT     = 1;

    localparam int unsigned OFS_COUNT  = 0;
    localparam int unsigned OFS_CTRL   = 1;
    localparam int unsigned OFS_LIMIT  = 2;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_LIMIT = 2'd3
    } reg_sel_e;

    // Base address of each timer's register group
    function automatic int unsigned timer_base(int unsigned idx);
        if (idx == 0) return 32'h021;
        return 32'h100 * idx;
    endfunction

endpackage

// File: rtl/timer_addr_decode.sv
module timer_addr_decode
    import dtimer_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned NUM_TIMERS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o [NUM_TIMERS]
);

    logic [NUM_TIMERS-1:0] hit;

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_dec
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(timer_base(t));
        always_comb begin
            sel_o[t] = SEL_NONE;
            if (addr_i == BASE + ADDR_W'(OFS_COUNT))      sel_o[t] = SEL_COUNT;
            else if (addr_i == BASE + ADDR_W'(OFS_CTRL))  sel_o[t] = SEL_CTRL;
            else if (addr_i == BASE + ADDR_W'(OFS_LIMIT)) sel_o[t] = SEL_LIMIT;
        end
        assign hit[t] = (sel_o[t] != SEL_NONE);
    end

    // R2
    one_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import dtimer_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halted_i,
    input  reg_sel_e          sel_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] limit;
        logic              nh;
        logic              ie;
        logic              pend;
    } chan_state_t;

    chan_state_t state_d, state_q;
    logic        advance, at_limit, wr_count, wr_ctrl, wrap;

    always_comb begin
        wr_count = we_i && (sel_i == SEL_COUNT);
        wr_ctrl  = we_i && (sel_i == SEL_CTRL);
        advance  = state_q.nh ? !halted_i : 1'b1;
        at_limit = (state_q.count == state_q.limit);
        wrap     = advance && at_limit && !wr_count;

        state_d = state_q;
        if (advance) begin
            state_d.count = at_limit ? '0 : state_q.count + 1'b1;
        end
        if (wrap && state_q.ie) begin
            state_d.pend = 1'b1;
        end
        if (we_i) begin
            case (sel_i)
                SEL_COUNT: state_d.count = wdata_i;
                SEL_LIMIT: state_d.limit = wdata_i;
                SEL_CTRL: begin
                    state_d.ie   = wdata_i[IE_BIT];
                    state_d.nh   = wdata_i[NH_BIT];
                    state_d.pend = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        case (sel_i)
            SEL_COUNT: rdata_o = state_q.count;
            SEL_LIMIT: rdata_o = state_q.limit;
            SEL_CTRL:  rdata_o = {{(DATA_W-CTRL_W){1'b0}}, state_q.nh, state_q.ie};
            default:   rdata_o = '0;
        endcase
    end

    assign irq_o = state_q.pend;

    // R3
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_COUNT) |=> (state_q.count == $past(wdata_i)));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.nh && halted_i && !(we_i && sel_i == SEL_COUNT)) |=> $stable(state_q.count));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(state_q.nh && halted_i) && state_q.count == state_q.limit
         && !(we_i && sel_i == SEL_COUNT)) |=> (state_q.count == '0));

    // R7
    no_irq_without_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.ie && !irq_o) |=> !irq_o);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_CTRL) |=> !irq_o);

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(we_i && sel_i == SEL_CTRL)) |=> irq_o);

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dtimer_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NUM_TIMERS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_halted,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_we,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NUM_TIMERS-1:0] irq
);

    reg_sel_e          sel   [NUM_TIMERS];
    logic [DATA_W-1:0] rdata [NUM_TIMERS];

    timer_addr_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_TIMERS (NUM_TIMERS)
    ) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (reg_addr),
        .sel_o  (sel)
    );

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_chan
        timer_channel #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .halted_i (cpu_halted),
            .sel_i    (sel[t]),
            .we_i     (reg_we),
            .wdata_i  (reg_wdata),
            .rdata_o  (rdata[t]),
            .irq_o    (irq[t])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            reg_rdata = reg_rdata | rdata[t];
        end
    end

endmodule

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_halted = 1'b1;
    logic [11:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  irq;

    always #5 clk = ~clk;

    dual_interval_timer u_dual_interval_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_halted (cpu_halted),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

    localparam logic [11:0] T0_CNT = 12'h021, T0_CTL = 12'h022, T0_LIM = 12'h023;
    localparam logic [11:0] T1_CNT = 12'h100, T1_CTL = 12'h101, T1_LIM = 12'h102;

    typedef struct {
        logic [31:0] data;
        logic [1:0]  irqv;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    logic mon_req = 1'b0;
    logic done = 1'b0;

    // Monitor: pops one expected item per requested sample
    always @(negedge clk) begin
        if (mon_req && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (reg_rdata !== e.data || irq !== e.irqv) begin
                errors++;
                $display("FAIL %s: actual data=%h irq=%b expected data=%h irq=%b",
                         e.tag, reg_rdata, irq, e.data, e.irqv);
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [31:0] d,
                      input logic [1:0] iv, input string tag);
        exp_t e;
        @(posedge clk); #1;
        reg_addr = a;
        reg_we   = 1'b0;
        e.data = d; e.irqv = iv; e.tag = tag;
        q.push_back(e);
        mon_req = 1'b1;
        @(negedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic run_cycles(input int n);
        @(posedge clk); #1;
        cpu_halted = 1'b0;
        repeat (n) @(posedge clk);
        #1;
        cpu_halted = 1'b1;
    endtask

    // Write at the same edge where the halt input is released for one edge
    task automatic wr_while_running(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_we = 1'b1; cpu_halted = 1'b0;
        @(posedge clk); #1;
        reg_we = 1'b0; cpu_halted = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(T0_CNT, 32'h0, 2'b00, "R1 t0 count");
        rd(T0_LIM, 32'h0, 2'b00, "R1 t0 limit");
        rd(T0_CTL, 32'h0, 2'b00, "R1 t0 ctrl");
        rd(T1_CTL, 32'h0, 2'b00, "R1 t1 ctrl");

        // R4 halt gating, R3 count load, R2 readback
        wr(T0_CTL, 32'h2);
        wr(T0_LIM, 32'h5);
        wr(T0_CNT, 32'h3);
        rd(T0_CNT, 32'h3, 2'b00, "R3 t0 count load");
        repeat (4) @(posedge clk);
        rd(T0_CNT, 32'h3, 2'b00, "R4 frozen while halted");
        rd(T0_LIM, 32'h5, 2'b00, "R2 t0 limit readback");
        rd(T0_CTL, 32'h2, 2'b00, "R2 t0 ctrl readback");
        run_cycles(2);
        rd(T0_CNT, 32'h5, 2'b00, "R4 counts when not halted");
        run_cycles(1);
        rd(T0_CNT, 32'h0, 2'b00, "R6 wrap with R7 ie clear");

        // R7 interrupt enable, R8 sticky and acknowledge
        wr(T0_CTL, 32'h3);
        run_cycles(5);
        rd(T0_CNT, 32'h5, 2'b00, "R7 at limit no irq yet");
        run_cycles(1);
        rd(T0_CNT, 32'h0, 2'b01, "R7 irq on wrap");
        run_cycles(3);
        rd(T0_CNT, 32'h3, 2'b01, "R8 irq sticky");
        wr(T0_CTL, 32'h3);
        rd(T0_CNT, 32'h3, 2'b00, "R8 ctrl write clears irq");

        // R8 write wins over same-edge wrap
        wr(T0_CNT, 32'h5);
        wr_while_running(T0_CTL, 32'h3);
        rd(T0_CNT, 32'h0, 2'b00, "R8 ack wins over wrap");

        // R3 count write overrides increment
        wr_while_running(T0_CNT, 32'h2);
        rd(T0_CNT, 32'h2, 2'b00, "R3 write beats increment");

        // R5 and R10 on timer 1, halt held high throughout
        wr(T1_LIM, 32'hFFFF_FFFF);
        wr(T1_CTL, 32'h1);
        wr(T1_CNT, 32'hFFFF_FFFD);
        rd(T1_CNT, 32'hFFFF_FFFE, 2'b00, "R5 counts while halted");
        rd(T1_CNT, 32'hFFFF_FFFF, 2'b00, "R10 reaches all ones");
        rd(T1_CNT, 32'h0,         2'b10, "R10 full-range wrap with irq");

        // R9 independence
        rd(T0_CNT, 32'h2, 2'b10, "R9 t0 count untouched");
        wr(T1_CTL, 32'h0);
        rd(T0_CTL, 32'h3, 2'b00, "R9 t1 ack leaves t0 ctrl");

        // R2 unmapped addresses
        wr(12'h020, 32'h77);
        rd(12'h020, 32'h0, 2'b00, "R2 unmapped read zero");
        rd(12'h103, 32'h0, 2'b00, "R2 unmapped read zero high");
        rd(T0_CNT, 32'h2, 2'b00, "R2 unmapped write ignored");
        rd(T0_LIM, 32'h5, 2'b00, "R2 limit kept");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule